// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block issues one SDRAM READ to a row that is already open and returns exactly the number of data words the requester asked for. When the burst may be shortened, it ends it with a BURST TERMINATE command. That command is placed so that the last wanted word is the last one the memory drives. The placement follows the CAS latency. The latency is a static setting of 2 or 3 cycles, and the terminate command leads the last wanted word by one cycle less than the latency.

The memory runs in one of two burst modes, chosen by a static input. In fixed-length mode it returns `BURST_LEN` words per READ. In continuous-page mode it keeps streaming until it is stopped. A fixed burst is shortened only when auto precharge was not requested and the wanted count is below the programmed length. Otherwise the burst runs to its end, and the capture path strobes only the words that were asked for. A busy flag covers the whole transaction. No new request is taken while it is high.

Row activation, precharge, refresh, initialization, mode-register programming and writes are handled elsewhere.

Top module: `rdtrunc_seq`

## Requirements
- R1: A request with a nonzero `req_len` is accepted at a clock edge where `busy` is low. The READ appears on the command bus in the following cycle, carrying `req_bank` and `req_col`, and `busy` rises at the same edge. A request with `req_len` of zero is ignored, and so is any request made while `busy` is high.
- R2: The command bus {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} carries READ as 4'b0101, BURST TERMINATE as 4'b0110 and NOP as 4'b0111. Every cycle that carries neither READ nor BURST TERMINATE carries NOP.
- R3: When the burst is shortened to N words, BURST TERMINATE is sampled exactly N edges after the READ edge. That is CL-1 edges before the edge of the last wanted word. This holds for CL=2 (`cfg_cl3`=0) and for CL=3 (`cfg_cl3`=1).
- R4: For N=1, BURST TERMINATE is issued in the cycle right after READ, with no NOP between the two.
- R5: In fixed-length mode (`cfg_page`=0), a request with `req_len` >= `BURST_LEN` issues no BURST TERMINATE. The full `BURST_LEN` words are received, and `rd_valid` pulses `BURST_LEN` times.
- R6: In fixed-length mode with `req_autopre`=1, address bit `AP_BIT` (bit 10) is high during the READ and no BURST TERMINATE is issued. All `BURST_LEN` words occupy the bus, but `rd_valid` pulses only min(`req_len`,`BURST_LEN`) times.
- R7: In continuous-page mode (`cfg_page`=1), every request ends with BURST TERMINATE. Address bit 10 is low during the READ even when `req_autopre` is 1.
- R8: Word k (counting from 0) is sampled from `sd_dq_in` at the edge CL+k after the READ edge. It is presented on `rd_data`, with `rd_valid` high, for the one following cycle. The words come out in order, with exactly the strobe count given by R3, R5, R6 or R7.
- R9: `busy` falls at the edge that samples the last word the memory drives for the request.
- R10: `sd_dqm` is low for as long as `busy` is high, and high when the block is idle.
- R11: After reset, `busy` is low, the command bus carries NOP, `sd_dqm` is high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl3 | input | 1 | CAS latency: 0 = 2 cycles, 1 = 3 cycles |
| cfg_page | input | 1 | Burst mode: 1 = continuous page, 0 = fixed length |
| req_valid | input | 1 | Read request strobe |
| req_bank | input | BANK_W | Bank to read |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Wanted word count |
| req_autopre | input | 1 | Auto precharge requested |
| busy | output | 1 | Transaction in progress |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Column address with the auto-precharge bit |
| sd_dqm | output | 1 | Data mask |
| sd_dq_in | input | DATA_W | Read data from the memory |
| rd_valid | output | 1 | Captured word strobe |
| rd_data | output | DATA_W | Captured word |

## Verification
The bench contains a memory model that stops driving data CL-1 edges after it samples BURST TERMINATE. Because of this, a terminate placed one edge early loses the final word, and one placed late leaves an extra word on the bus. Either error shows up as a wrong bus-word count or as a wrong strobe count. The N=1 case at both latencies catches a design that puts a NOP between READ and the terminate. The N=`BURST_LEN`-1 and N=`BURST_LEN` cases catch an off-by-one in the decision to truncate. The auto-precharge case catches two faults: a design that still truncates, which is caught by the terminate and bus-word counts, and a design that drops `busy` once the wanted words are in, which is caught by the edge where `busy` falls. Further cases cover a zero-length request, a request made while busy, and continuous-page mode with auto precharge set; each would show as a second READ or as a high address bit 10.

// File: rtl/rdtrunc_pkg.sv
`timescale 1ns/1ps
package rdtrunc_pkg;
   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      SD_READ = 4'b0101,
      SD_TERM = 4'b0110,
      SD_NOP  = 4'b0111
   } sd_cmd_e;
endpackage

// File: rtl/rdtrunc_plan.sv
`timescale 1ns/1ps
// Decides, per request, whether the burst is cut short and how many words
// occupy the bus and how many are strobed to the requester.
module rdtrunc_plan #(
   parameter int LEN_W        = 10,
   parameter int BURST_LEN    = 8,
   parameter bit SUPPORT_PAGE = 1'b1
) (
   input  logic [LEN_W-1:0] len,
   input  logic             autopre,
   input  logic             page,
   output logic             trunc,
   output logic             ap_bit,
   output logic [LEN_W-1:0] bus_words,
   output logic [LEN_W-1:0] strobe_words
);
   localparam logic [LEN_W-1:0] BL = LEN_W'(BURST_LEN);

   logic page_eff;
   logic short_req;

   generate
      if (SUPPORT_PAGE) begin : g_page
         assign page_eff = page;
      end else begin : g_fixed
         logic unused_page;
         assign unused_page = page;
         assign page_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      short_req    = (len < BL);
      trunc        = page_eff | (~autopre & short_req);
      ap_bit       = ~page_eff & autopre;
      bus_words    = trunc ? len : BL;
      strobe_words = (trunc | short_req) ? len : BL;
   end
endmodule

// File: rtl/rdtrunc_cmd.sv
`timescale 1ns/1ps
// Command sequencer: issues READ, counts edges from the READ edge, places
// BURST TERMINATE, and flags which edges carry returned words.
module rdtrunc_cmd
   import rdtrunc_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10,
   parameter int LEN_W  = 10,
   parameter int CYC_W  = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cl3,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic              trunc,
   input  logic              ap_bit,
   input  logic [LEN_W-1:0]  bus_words,
   input  logic [LEN_W-1:0]  strobe_words,
   output logic              busy,
   output sd_cmd_e           cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr,
   output logic              dqm,
   output logic              cap_strobe
);
   logic              busy_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [LEN_W-1:0]  words_q;
   logic [LEN_W-1:0]  strobes_q;
   logic              trunc_q;
   logic              cl3_q;
   sd_cmd_e           cmd_q;
   logic [BANK_W-1:0] ba_q;
   logic [ADDR_W-1:0] addr_q;
   logic              dqm_q;

   logic [CYC_W-1:0]  lat;
   logic [CYC_W-1:0]  word_idx;
   logic              in_data;
   logic              last_word;
   logic              term_next;
   logic [ADDR_W-1:0] addr_next;

   always_comb begin
      lat       = cl3_q ? CYC_W'(3) : CYC_W'(2);
      in_data   = busy_q && (cyc_q >= lat);
      word_idx  = cyc_q - lat;
      last_word = in_data && (word_idx == CYC_W'(words_q) - CYC_W'(1));
      term_next = trunc_q && ((cyc_q + CYC_W'(1)) == CYC_W'(words_q));
      addr_next = '0;
      addr_next[COL_W-1:0] = col;
      addr_next[AP_BIT]    = ap_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cyc_q     <= '0;
         words_q   <= '0;
         strobes_q <= '0;
         trunc_q   <= 1'b0;
         cl3_q     <= 1'b0;
         cmd_q     <= SD_NOP;
         ba_q      <= '0;
         addr_q    <= '0;
         dqm_q     <= 1'b1;
      end else if (start) begin
         busy_q    <= 1'b1;
         cyc_q     <= '0;
         words_q   <= bus_words;
         strobes_q <= strobe_words;
         trunc_q   <= trunc;
         cl3_q     <= cl3;
         cmd_q     <= SD_READ;
         ba_q      <= bank;
         addr_q    <= addr_next;
         dqm_q     <= 1'b0;
      end else if (busy_q) begin
         cyc_q <= cyc_q + CYC_W'(1);
         cmd_q <= term_next ? SD_TERM : SD_NOP;
         if (last_word) begin
            busy_q <= 1'b0;
            dqm_q  <= 1'b1;
         end
      end
   end

   assign busy       = busy_q;
   assign cmd        = cmd_q;
   assign ba         = ba_q;
   assign addr       = addr_q;
   assign dqm        = dqm_q;
   assign cap_strobe = in_data && (word_idx < CYC_W'(strobes_q));
endmodule

// File: rtl/rdtrunc_cap.sv
`timescale 1ns/1ps
// Read-data capture register with a one-cycle valid strobe.
module rdtrunc_cap #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] dq,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= strobe;
         if (strobe) data <= dq;
      end
   end
endmodule

// File: rtl/rdtrunc_seq.sv
`timescale 1ns/1ps
module rdtrunc_seq
   import rdtrunc_pkg::*;
#(
   parameter int BANK_W       = 2,
   parameter int COL_W        = 9,
   parameter int ADDR_W       = 12,
   parameter int AP_BIT       = 10,
   parameter int LEN_W        = 10,
   parameter int BURST_LEN    = 8,
   parameter int DATA_W       = 16,
   parameter bit SUPPORT_PAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cl3,
   input  logic              cfg_page,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_autopre,
   output logic              busy,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              sd_dqm,
   input  logic [DATA_W-1:0] sd_dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int CYC_W = LEN_W + 1;

   generate
      if (AP_BIT >= ADDR_W || COL_W > AP_BIT) begin : g_bad_addr
         $error("rdtrunc_seq: column must fit below AP_BIT, AP_BIT inside ADDR_W");
      end
      if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("rdtrunc_seq: BURST_LEN must be 1, 2, 4 or 8");
      end
      if (LEN_W < 4 || (SUPPORT_PAGE && LEN_W < COL_W + 1)) begin : g_bad_len
         $error("rdtrunc_seq: LEN_W too narrow for the burst or page length");
      end
   endgenerate

   logic             trunc;
   logic             ap_bit;
   logic [LEN_W-1:0] bus_words;
   logic [LEN_W-1:0] strobe_words;
   logic             start;
   logic             cap_strobe;
   sd_cmd_e          cmd;

   assign start = req_valid && !busy && (req_len != '0);

   rdtrunc_plan #(
      .LEN_W(LEN_W), .BURST_LEN(BURST_LEN), .SUPPORT_PAGE(SUPPORT_PAGE)
   ) u_plan (
      .len(req_len), .autopre(req_autopre), .page(cfg_page),
      .trunc(trunc), .ap_bit(ap_bit),
      .bus_words(bus_words), .strobe_words(strobe_words)
   );

   rdtrunc_cmd #(
      .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
      .LEN_W(LEN_W), .CYC_W(CYC_W)
   ) u_cmd (
      .clk(clk), .rst_n(rst_n), .start(start), .cl3(cfg_cl3),
      .bank(req_bank), .col(req_col), .trunc(trunc), .ap_bit(ap_bit),
      .bus_words(bus_words), .strobe_words(strobe_words),
      .busy(busy), .cmd(cmd), .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm),
      .cap_strobe(cap_strobe)
   );

   rdtrunc_cap #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .dq(sd_dq_in),
      .valid(rd_valid), .data(rd_data)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/rdtrunc_seq_chk.sv
`timescale 1ns/1ps
module rdtrunc_seq_chk #(
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [3:0]        cmd,
   input logic [ADDR_W-1:0] addr,
   input logic              dqm,
   input logic              rd_valid
);
   localparam logic [3:0] C_READ = 4'b0101;
   localparam logic [3:0] C_TERM = 4'b0110;
   localparam logic [3:0] C_NOP  = 4'b0111;

   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_READ) || (cmd == C_TERM) || (cmd == C_NOP));                 // R2
   AST_READ_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_READ) |-> $rose(busy));                                     // R1
   AST_ONE_READ_PER_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cmd != C_READ));                           // R1
   AST_DQM_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dqm);                                                       // R10
   AST_TERM_NO_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_TERM) |-> !addr[AP_BIT]);                                   // R6
   AST_TERM_INSIDE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_TERM) |-> (busy && $past(busy)));                           // R3
   AST_VALID_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(busy));                                            // R8
endmodule

bind rdtrunc_seq rdtrunc_seq_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy),
   .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
   .addr(sd_addr), .dqm(sd_dqm), .rd_valid(rd_valid)
);

// File: tb/rdtrunc_seq_bench.sv
`timescale 1ns/1ps
module rdtrunc_seq_bench;
   localparam int BL = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_cl3 = 1'b0, cfg_page = 1'b0;
   logic        req_valid = 1'b0, req_autopre = 1'b0;
   logic [1:0]  req_bank = '0;
   logic [8:0]  req_col = '0;
   logic [9:0]  req_len = '0;
   logic        busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_valid;
   logic [1:0]  sd_ba;
   logic [11:0] sd_addr;
   logic [15:0] sd_dq_in = 16'hDEAD;
   logic [15:0] rd_data;

   int checks = 0, failures = 0;

   always #2 clk = ~clk;

   rdtrunc_seq u_rdtrunc_seq (
      .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_page(cfg_page),
      .req_valid(req_valid), .req_bank(req_bank), .req_col(req_col),
      .req_len(req_len), .req_autopre(req_autopre), .busy(busy),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   function automatic logic [15:0] pat(input logic [1:0] b, input logic [8:0] c, input int idx);
      logic [15:0] colsum;
      colsum = 16'(c) + 16'(idx);
      return (16'(b) << 14) ^ colsum ^ 16'h2400;
   endfunction

   // tracking, cleared per scenario
   int edge_n = 0, reads = 0, rd_edge = 0, bt_cnt = 0, bt_edge = -1;
   int m_stop = 0, m_lim = 0, bus_words = 0, last_bus_edge = -1, busy_low_edge = -1;
   int strobes = 0, data_bad = 0, dqm_bad = 0, a10_seen = 0, busy_seen = 0;
   logic [1:0] m_bank = '0, exp_bank = '0;
   logic [8:0] m_col = '0, exp_col = '0;

   // memory model
   always @(posedge clk) begin
      logic [3:0] cv;
      int cl, nxt, idx;
      edge_n++;
      cv = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      cl = cfg_cl3 ? 3 : 2;
      if (rst_n) begin
         if (busy) busy_seen = 1;
         if (reads > 0 && !busy && busy_low_edge < 0) busy_low_edge = edge_n;
         if (cv == 4'b0101) begin
            reads++;
            rd_edge  = edge_n;
            m_bank   = sd_ba;
            m_col    = sd_addr[8:0];
            a10_seen = int'(sd_addr[10]);
            m_stop   = 1 << 30;
            m_lim    = cfg_page ? 512 : BL;
         end
         if (cv == 4'b0110) begin
            bt_cnt++;
            bt_edge = edge_n;
            m_stop  = edge_n + cl - 1;
         end
         nxt = edge_n + 1;
         idx = nxt - rd_edge - cl;
         if (reads > 0 && idx >= 0 && nxt <= m_stop && idx < m_lim) begin
            sd_dq_in <= pat(m_bank, m_col, idx);
            bus_words++;
            last_bus_edge = nxt;
         end else begin
            sd_dq_in <= 16'hDEAD;
         end
      end
   end

   // output monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && sd_dqm) dqm_bad++;
         if (rd_valid) begin
            if (rd_data !== pat(exp_bank, exp_col, strobes)) data_bad++;
            strobes++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_track();
      reads = 0; bt_cnt = 0; bt_edge = -1; bus_words = 0; last_bus_edge = -1;
      busy_low_edge = -1; strobes = 0; data_bad = 0; dqm_bad = 0; a10_seen = 0;
      busy_seen = 0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 2000) begin @(negedge clk); n++; end
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_req(input logic [1:0] b, input logic [8:0] c, input int len, input bit ap);
      req_bank = b; req_col = c; req_len = 10'(len); req_autopre = ap; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // one complete read, with every expectation checked
   task automatic run_case(input string tag, input logic [1:0] b, input logic [8:0] c,
                           input int len, input bit ap, input bit cl3, input bit page,
                           input int exp_bt, input int exp_bus, input int exp_strb,
                           input int exp_a10);
      @(negedge clk);
      cfg_cl3 = cl3; cfg_page = page; exp_bank = b; exp_col = c;
      clear_track();
      pulse_req(b, c, len, ap);
      wait_idle();
      chk(reads == 1, {tag, " R1 one READ"}, reads, 1);
      if (exp_bt < 0)
         chk(bt_cnt == 0, {tag, " no terminate"}, bt_cnt, 0);
      else
         chk(bt_cnt == 1 && bt_edge - rd_edge == exp_bt, {tag, " R3 terminate offset"},
             bt_edge - rd_edge, exp_bt);
      chk(bus_words == exp_bus, {tag, " R3 words on bus"}, bus_words, exp_bus);
      chk(strobes == exp_strb, {tag, " R8 strobe count"}, strobes, exp_strb);
      chk(data_bad == 0, {tag, " R8 data order"}, data_bad, 0);
      chk(busy_low_edge == last_bus_edge + 1, {tag, " R9 busy fall edge"},
          busy_low_edge, last_bus_edge + 1);
      chk(a10_seen == exp_a10, {tag, " R6 R7 auto-precharge bit"}, a10_seen, exp_a10);
      chk(dqm_bad == 0, {tag, " R10 dqm low while busy"}, dqm_bad, 0);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R11 R2 NOP after reset",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
      chk(sd_dqm == 1'b1, "R11 R10 dqm idle high", int'(sd_dqm), 1);
      chk(rd_valid == 1'b0, "R11 valid after reset", int'(rd_valid), 0);
   endtask

   task automatic t_zero_len();
      @(negedge clk);
      cfg_cl3 = 1'b0; cfg_page = 1'b0;
      clear_track();
      pulse_req(2'd1, 9'd4, 0, 1'b0);
      repeat (10) @(negedge clk);
      chk(reads == 0, "R1 zero length ignored READ", reads, 0);
      chk(busy_seen == 0, "R1 zero length ignored busy", busy_seen, 0);
   endtask

   task automatic t_busy_req();
      @(negedge clk);
      cfg_cl3 = 1'b1; cfg_page = 1'b0; exp_bank = 2'd2; exp_col = 9'd40;
      clear_track();
      pulse_req(2'd2, 9'd40, 5, 1'b0);
      @(negedge clk);
      pulse_req(2'd3, 9'd90, 2, 1'b0);
      wait_idle();
      chk(reads == 1, "R1 request while busy ignored", reads, 1);
      chk(strobes == 5, "R1 R8 strobes of first request only", strobes, 5);
      chk(data_bad == 0, "R1 R8 data of first request", data_bad, 0);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      //        tag               bank col   len ap cl3 pg  bt  bus strb a10
      run_case("R3 cl2 len3",     2'd0, 9'd16, 3, 0, 0, 0,  3,  3,  3, 0);
      run_case("R3 cl3 len3",     2'd1, 9'd20, 3, 0, 1, 0,  3,  3,  3, 0);
      run_case("R4 cl2 len1",     2'd2, 9'd7,  1, 0, 0, 0,  1,  1,  1, 0);
      run_case("R4 cl3 len1",     2'd3, 9'd8,  1, 0, 1, 0,  1,  1,  1, 0);
      run_case("R3 cl2 len7",     2'd1, 9'd100,7, 0, 0, 0,  7,  7,  7, 0);
      run_case("R5 cl3 len8",     2'd0, 9'd200,8, 0, 1, 0, -1,  8,  8, 0);
      run_case("R5 cl2 len12",    2'd2, 9'd300,12,0, 0, 0, -1,  8,  8, 0);
      run_case("R6 autopre len3", 2'd3, 9'd64, 3, 1, 0, 0, -1,  8,  3, 1);
      run_case("R6 autopre cl3",  2'd1, 9'd65, 9, 1, 1, 0, -1,  8,  8, 1);
      run_case("R7 page cl3",     2'd2, 9'd500,20,1, 1, 1, 20, 20, 20, 0);
      run_case("R7 page cl2",     2'd0, 9'd3,  2, 0, 0, 1,  2,  2,  2, 0);
      t_zero_len();
      t_busy_req();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule